// File: doc/BRIEF.md
# Dual-Channel Receive Byte Holding Register with Interrupt Gating

This block sits behind two recovered-bit streams. For each of two channels it takes one bit per strobe, each bit marked good or bad, packs good bits into bytes most significant bit first, and drops each finished byte into a one-entry holding slot for a host to read. A run of bad bits after a frame has started ends the frame. The block then pushes any partly built byte into the slot, left-aligned with zero fill below.

Per channel, four status conditions are kept: slot full, slot overwritten before it was read (overflow), slot read while empty (underflow), and frame end. The eight status bits are masked by an 8-bit enable register, and the results are ORed into one interrupt line. The host reaches everything through a small synchronous register port. Read data appears one cycle after the read strobe, and the read has its side effects on that same clock edge.

Register addresses: 0 is the interrupt enable (read/write), 1 is the frame-end length in bits [3:0] (read/write), 2 is status (read only, clear on read), 3 is the channel A slot and 4 is the channel B slot (both read only). Other addresses read as 0x00.

Top module: `dual_rx_holding`

## Requirements
- R1: After reset the enable register, the length field, all status bits and `irq` are 0.
- R2: A channel packs good bits most significant bit first. After the eighth good bit the byte is in that channel's slot and the channel's full bit is set in status (bit 0 for A, bit 4 for B).
- R3: Bad bits that arrive before any good bit since reset or since the last frame end never cause a frame end. Bad bits that stop short of the limit leave the pending bits intact.
- R4: With length L, frame end (status bit 1 for A, bit 5 for B) is declared on the (L+1)-th consecutive bad bit after a good bit. Any good bit restarts the count, so L=0 ends the frame on the first bad bit.
- R5: At frame end, a pending partial byte of n bits (n > 0) is loaded with those bits in the top n positions and zeros below, and the full bit is set. With no pending bits, nothing is loaded.
- R6: Reading a slot returns its byte and clears the full bit. Reading an empty slot returns 0x00 and sets the underflow bit (bit 3 for A, bit 7 for B).
- R7: Loading a byte into a full slot that is not being read in the same cycle sets the overflow bit (bit 2 for A, bit 6 for B), and the slot then holds the new byte.
- R8: A status read returns all eight bits and clears the underflow, overflow and frame-end bits. It leaves the full bits unchanged. An event in the same cycle as the clear stays set.
- R9: `irq` is the OR of status AND enable, bit by bit, in the same layout. It drops in the cycle after the enabled bits are cleared or masked.
- R10: The two channels assemble and report independently, even when they receive at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 2 | Per-channel bit strobe (bit 0 = A, bit 1 = B) |
| bit_good | input | 2 | Per-channel flag: the strobed bit is good |
| bit_din | input | 2 | Per-channel bit value |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after `host_rd` |
| irq | output | 1 | Masked interrupt request |

## Verification
On every cycle, the assertions check the following. A load always fills the slot with the offered byte. A slot read with no load in the same cycle always empties it. A frame end always returns the assembler to its idle state. Any overflow, underflow or frame-end event is visible in status on the next cycle. A status read with no new events leaves the sticky bits clear.

Only the bench scenarios can show the rest: the bit ordering of packed and flushed bytes, the exact bad-bit count at which a frame ends for lengths 0, 2 and 15, the bad bits ignored before a frame, the masking and release of `irq` through the enable register, and two channels receiving at once.

// File: rtl/rxhold_pkg.sv
package rxhold_pkg;

    localparam int BYTE_W = 8;
    localparam int NCH    = 2;
    localparam int LEN_W  = 4;
    localparam int ADDR_W = 3;
    localparam int STS_W  = 4 * NCH;

    localparam logic [ADDR_W-1:0] ADR_IEN   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CFG   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_STS   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_HOLD0 = 3'd3;

    // per-channel status nibble, most significant field first
    typedef struct packed {
        logic udf;
        logic ovf;
        logic eof;
        logic full;
    } chan_sts_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } load_t;

    function automatic logic [ADDR_W-1:0] hold_addr(input int ch);
        return ADR_HOLD0 + ADDR_W'(ch);
    endfunction

endpackage

// File: rtl/rx_bit_packer.sv
module rx_bit_packer
    import rxhold_pkg::*;
#(
    parameter int PK_BYTE_W = BYTE_W,
    parameter int PK_LEN_W  = LEN_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic                good,
    input  logic                din,
    input  logic [PK_LEN_W-1:0] eof_len,
    output load_t               ld,
    output logic                eof_pulse
);

    localparam int CW    = $clog2(PK_BYTE_W + 1);
    localparam int RUN_W = PK_LEN_W + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [PK_BYTE_W-1:0] shreg_q, shreg_n;
    logic [CW-1:0]        cnt_q, cnt_n;
    logic [RUN_W-1:0]     run_q, run_n, run_inc;
    logic                 in_frame_q, in_frame_n;
    logic [PK_BYTE_W-1:0] shifted;

    always_comb begin
        shreg_n    = shreg_q;
        cnt_n      = cnt_q;
        run_n      = run_q;
        in_frame_n = in_frame_q;
        ld         = '0;
        eof_pulse  = 1'b0;
        shifted    = {shreg_q[PK_BYTE_W-2:0], din};
        run_inc    = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
        if (stb && good) begin
            in_frame_n = 1'b1;
            run_n      = '0;
            if (cnt_q == CW'(PK_BYTE_W - 1)) begin
                ld.vld  = 1'b1;
                ld.data = shifted;
                shreg_n = '0;
                cnt_n   = '0;
            end else begin
                shreg_n = shifted;
                cnt_n   = cnt_q + 1'b1;
            end
        end else if (stb && in_frame_q) begin
            if (run_inc > {1'b0, eof_len}) begin
                eof_pulse  = 1'b1;
                if (cnt_q != '0) begin
                    ld.vld  = 1'b1;
                    ld.data = shreg_q << (PK_BYTE_W - int'(cnt_q));
                end
                shreg_n    = '0;
                cnt_n      = '0;
                run_n      = '0;
                in_frame_n = 1'b0;
            end else begin
                run_n = run_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q    <= '0;
            cnt_q      <= '0;
            run_q      <= '0;
            in_frame_q <= 1'b0;
        end else begin
            shreg_q    <= shreg_n;
            cnt_q      <= cnt_n;
            run_q      <= run_n;
            in_frame_q <= in_frame_n;
        end
    end

    p_eof_idle_r4: assert property (@(posedge clk) disable iff (rst)
        eof_pulse |=> (!in_frame_q && cnt_q == '0 && run_q == '0));

endmodule

// File: rtl/rx_hold_slot.sv
module rx_hold_slot
    import rxhold_pkg::*;
#(
    parameter int SL_BYTE_W = BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  load_t                ld,
    input  logic                 rd,
    output logic                 full_q,
    output logic [SL_BYTE_W-1:0] rd_byte,
    output logic                 ovf_evt,
    output logic                 udf_evt
);

    logic [SL_BYTE_W-1:0] data_q;

    assign ovf_evt = ld.vld && full_q && !rd;
    assign udf_evt = rd && !full_q;
    assign rd_byte = full_q ? data_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (rd)
                full_q <= 1'b0;
            if (ld.vld) begin
                data_q <= ld.data;
                full_q <= 1'b1;
            end
        end
    end

    p_load_fills_r2: assert property (@(posedge clk) disable iff (rst)
        ld.vld |=> (full_q && data_q == $past(ld.data)));

    p_read_empties_r6: assert property (@(posedge clk) disable iff (rst)
        (rd && !ld.vld) |=> !full_q);

endmodule

// File: rtl/rx_irq_gate.sv
module rx_irq_gate
    import rxhold_pkg::*;
#(
    parameter int G_NCH = NCH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [G_NCH-1:0]   full,
    input  logic [G_NCH-1:0]   udf_evt,
    input  logic [G_NCH-1:0]   ovf_evt,
    input  logic [G_NCH-1:0]   eof_evt,
    input  logic               sts_rd,
    input  logic [4*G_NCH-1:0] ien,
    output logic [4*G_NCH-1:0] sts,
    output logic               irq
);

    logic [G_NCH-1:0] udf_q, ovf_q, eof_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            udf_q <= '0;
            ovf_q <= '0;
            eof_q <= '0;
        end else begin
            udf_q <= (sts_rd ? '0 : udf_q) | udf_evt;
            ovf_q <= (sts_rd ? '0 : ovf_q) | ovf_evt;
            eof_q <= (sts_rd ? '0 : eof_q) | eof_evt;
        end
    end

    for (genvar c = 0; c < G_NCH; c++) begin : g_sts
        chan_sts_t nib;
        assign nib.udf  = udf_q[c];
        assign nib.ovf  = ovf_q[c];
        assign nib.eof  = eof_q[c];
        assign nib.full = full[c];
        assign sts[4*c +: 4] = nib;

        p_evt_sticks_r8: assert property (@(posedge clk) disable iff (rst)
            (udf_evt[c] || ovf_evt[c] || eof_evt[c]) |=>
            ((udf_q[c] || !$past(udf_evt[c])) && (ovf_q[c] || !$past(ovf_evt[c]))
             && (eof_q[c] || !$past(eof_evt[c]))));
    end

    assign irq = |(sts & ien);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (sts_rd && !(|udf_evt) && !(|ovf_evt) && !(|eof_evt)) |=>
        (udf_q == '0 && ovf_q == '0 && eof_q == '0));

endmodule

// File: rtl/dual_rx_holding.sv
module dual_rx_holding
    import rxhold_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    bit_stb,
    input  logic [NCH-1:0]    bit_good,
    input  logic [NCH-1:0]    bit_din,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              irq
);

    logic [STS_W-1:0]  ien_q;
    logic [LEN_W-1:0]  eof_len_q;
    logic [STS_W-1:0]  sts;
    logic [NCH-1:0]    full, udf_evt, ovf_evt, eof_evt, rd_hold;
    logic [BYTE_W-1:0] rd_byte [NCH];
    logic [BYTE_W-1:0] rd_mux;
    logic              sts_rd;

    assign sts_rd = host_rd && host_addr == ADR_STS;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        load_t ld;

        assign rd_hold[c] = host_rd && host_addr == hold_addr(c);

        rx_bit_packer #(.PK_BYTE_W(BYTE_W), .PK_LEN_W(LEN_W)) u_pack (
            .clk       (clk),
            .rst       (rst),
            .stb       (bit_stb[c]),
            .good      (bit_good[c]),
            .din       (bit_din[c]),
            .eof_len   (eof_len_q),
            .ld        (ld),
            .eof_pulse (eof_evt[c])
        );

        rx_hold_slot #(.SL_BYTE_W(BYTE_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .ld      (ld),
            .rd      (rd_hold[c]),
            .full_q  (full[c]),
            .rd_byte (rd_byte[c]),
            .ovf_evt (ovf_evt[c]),
            .udf_evt (udf_evt[c])
        );
    end

    rx_irq_gate #(.G_NCH(NCH)) u_gate (
        .clk     (clk),
        .rst     (rst),
        .full    (full),
        .udf_evt (udf_evt),
        .ovf_evt (ovf_evt),
        .eof_evt (eof_evt),
        .sts_rd  (sts_rd),
        .ien     (ien_q),
        .sts     (sts),
        .irq     (irq)
    );

    always_comb begin
        rd_mux = '0;
        case (host_addr)
            ADR_IEN: rd_mux = BYTE_W'(ien_q);
            ADR_CFG: rd_mux = BYTE_W'(eof_len_q);
            ADR_STS: rd_mux = BYTE_W'(sts);
            default: begin
                for (int c = 0; c < NCH; c++)
                    if (host_addr == hold_addr(c)) rd_mux = rd_byte[c];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q      <= '0;
            eof_len_q  <= '0;
            host_rdata <= '0;
        end else begin
            if (host_wr && host_addr == ADR_IEN) ien_q     <= host_wdata[STS_W-1:0];
            if (host_wr && host_addr == ADR_CFG) eof_len_q <= host_wdata[LEN_W-1:0];
            if (host_rd) host_rdata <= rd_mux;
        end
    end

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(host_wr) && $past(host_addr) == ADR_IEN && $past(host_wdata) == '0) |-> !irq);

endmodule

// File: tb/dual_rx_holding_tb.sv
module dual_rx_holding_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bit_stb = '0, bit_good = '0, bit_din = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 1'b0;

    always #5 clk = ~clk;

    dual_rx_holding dut_i (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_good(bit_good), .bit_din(bit_din),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard
    always @(posedge clk) rd_seen <= host_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(host_rdata, e, t);
        end
    end

    task automatic rd_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
        host_addr = a; host_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic send_bit(input int ch, input logic good, input logic d);
        bit_stb[ch] = 1'b1; bit_good[ch] = good; bit_din[ch] = d;
        @(negedge clk);
        bit_stb[ch] = 1'b0;
    endtask

    task automatic send_byte(input int ch, input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(ch, 1'b1, b[i]);
    endtask

    task automatic send_bad(input int ch, input int n);
        for (int i = 0; i < n; i++) send_bit(ch, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({7'd0, irq}, 8'h00, "R1 irq after reset");
        rd_reg(3'd0, 8'h00, "R1 enable reset");
        rd_reg(3'd1, 8'h00, "R1 length reset");
        rd_reg(3'd2, 8'h00, "R1 status reset");

        // R2 packing MSB first
        send_byte(0, 8'hA5);
        rd_reg(3'd2, 8'h01, "R2 full A");
        rd_reg(3'd3, 8'hA5, "R2 byte A");
        rd_reg(3'd2, 8'h00, "R6 full cleared");

        // R6 underflow, R8 clear
        rd_reg(3'd3, 8'h00, "R6 empty read");
        rd_reg(3'd2, 8'h08, "R6 underflow A");
        rd_reg(3'd2, 8'h00, "R8 sticky cleared");

        // R7 overflow
        send_byte(0, 8'h3C);
        send_byte(0, 8'hC3);
        rd_reg(3'd2, 8'h05, "R7 overflow A");
        rd_reg(3'd3, 8'hC3, "R7 newest byte kept");
        rd_reg(3'd2, 8'h00, "R8 after overflow");

        // R3/R4/R5 length 2 on channel B
        wr_reg(3'd1, 8'h02);
        rd_reg(3'd1, 8'h02, "R4 length readback");
        send_bad(1, 5);
        rd_reg(3'd2, 8'h00, "R3 no frame end before good bit");
        send_bit(1, 1'b1, 1'b1); send_bit(1, 1'b1, 1'b0); send_bit(1, 1'b1, 1'b1);
        send_bad(1, 2);
        send_bit(1, 1'b1, 1'b1);
        send_bad(1, 2);
        rd_reg(3'd2, 8'h00, "R4 run at limit no frame end");
        send_bad(1, 1);
        rd_reg(3'd2, 8'h30, "R4 frame end B and flush");
        rd_reg(3'd4, 8'hB0, "R5 partial byte B left aligned");

        // R5 no flush with nothing pending, length 0
        wr_reg(3'd1, 8'h00);
        send_byte(0, 8'h11);
        send_bad(0, 1);
        rd_reg(3'd2, 8'h03, "R4 length 0 frame end A");
        rd_reg(3'd3, 8'h11, "R5 full byte only");
        rd_reg(3'd2, 8'h00, "R5 no extra load");

        // R9 interrupt masking
        wr_reg(3'd0, 8'h02);
        chk({7'd0, irq}, 8'h00, "R9 irq idle");
        send_bit(0, 1'b1, 1'b1);
        send_bad(0, 1);
        chk({7'd0, irq}, 8'h01, "R9 irq on frame end A");
        wr_reg(3'd0, 8'h08);
        chk({7'd0, irq}, 8'h00, "R9 irq masked");
        wr_reg(3'd0, 8'h02);
        chk({7'd0, irq}, 8'h01, "R9 irq unmasked");
        rd_reg(3'd2, 8'h03, "R9 status");
        chk({7'd0, irq}, 8'h00, "R9 irq drops after clear");
        rd_reg(3'd3, 8'h80, "R5 single bit flush");

        // R10 simultaneous channels
        fork
            send_byte(0, 8'hF0);
            send_byte(1, 8'h0F);
        join
        rd_reg(3'd2, 8'h11, "R10 both full");
        rd_reg(3'd3, 8'hF0, "R10 byte A");
        rd_reg(3'd4, 8'h0F, "R10 byte B");

        // R4 length 15
        wr_reg(3'd1, 8'h0F);
        send_bit(1, 1'b1, 1'b1);
        send_bad(1, 15);
        rd_reg(3'd2, 8'h00, "R4 length 15 not yet");
        send_bad(1, 1);
        rd_reg(3'd2, 8'h30, "R4 length 15 frame end");
        rd_reg(3'd4, 8'h80, "R5 flush B");

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule